// File: doc/BRIEF.md
# Indirect Controller Register Port

This block is the host-facing register file of a network controller. The host sees a four-word I/O window. One word holds an index pointer. Two other words are data ports, and each reaches the register that the pointer selects in its own bank. One bank holds control and status registers; the other holds bus configuration registers. Reading the fourth word resets the controller's command state.

Register 0 of the control bank is the command and status word. Writing it issues one-cycle command pulses: start initialisation, start operation, or poll transmit now. The word also carries the persistent stop and running status. An init-done flag rises a fixed, parameterised number of cycles after an init command, which stands in for the init-block fetch. A read-only pair of control indices returns a 32-bit identification word. A few stored registers drive configuration fields that neighbouring blocks read: the init-block address, the transmit start threshold, no-underflow mode and 32-bit descriptor style.

Top module: `netc_regport`

## Requirements
- R1: A write to byte offset 0x12 loads `wdata[6:0]` into the 7-bit index pointer. A read of 0x12 returns the pointer, zero-extended to 16 bits.
- R2: Offset 0x10 reads or writes the control register that the pointer selects, and offset 0x16 does the same for the configuration register. Control indices 1, 2, 4 and 80 and configuration indices 2, 18, 20 and 32 store the full 16-bit word. The two banks are separate.
- R3: A register index that is not implemented in a bank reads as zero, and a write to it changes nothing.
- R4: After reset, every stored register and the pointer are zero, all pulses are low, and control register 0 reads 0x0004.
- R5: In control register 0, a write with bit 0 set gives a one-cycle `init_pulse` and clears stop (bit 2). A write with bit 1 set gives a one-cycle `start_pulse`, sets running (bit 1 reads 1) and clears stop. A write with bit 2 set sets stop and clears running. Bit 2 overrides bits 0 and 1 in the same write, and then no pulse is issued. Bits 0 and 3 always read as zero.
- R6: A write of control register 0 with bit 3 set gives a one-cycle `tx_poll_pulse` and leaves the stop and running status unchanged.
- R7: `init_done` (control register 0 bit 8) rises exactly `INIT_CYCLES` clock edges after the edge that accepts the init write.
- R8: Writing control register 0 with bit 8 set clears `init_done`. A write with bit 8 clear leaves it set.
- R9: Reading offset 0x14 returns zero and gives a one-cycle `soft_rst_pulse`. It returns control register 0 to 0x0004 and cancels any pending init. It keeps the pointer and all stored registers.
- R10: Control index 88 reads bits 15:0 and index 89 reads bits 31:16 of the ID word {4'b0, `PART_CODE`, 12'h003} (0x5003 and 0x0262 by default). Writes to these indices are ignored.
- R11: `init_blk_addr` equals {control reg 2, control reg 1}. `tx_thresh` equals control reg 80 bits 11:10. `no_underflow` equals configuration reg 18 bit 11. `desc32` is high when configuration reg 20 bits 7:0 equal 2.
- R12: `rdata` is loaded at the clock edge that accepts a read and holds at all other times. Offsets other than 0x10, 0x12, 0x14 and 0x16 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 5 | Byte offset in the I/O window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| init_pulse | output | 1 | Start-initialisation command pulse |
| start_pulse | output | 1 | Start-operation command pulse |
| tx_poll_pulse | output | 1 | Transmit-poll command pulse |
| soft_rst_pulse | output | 1 | Software reset pulse |
| stopped | output | 1 | Stop status |
| running | output | 1 | Running status |
| init_done | output | 1 | Initialisation complete flag |
| init_blk_addr | output | 32 | Init block address |
| tx_thresh | output | 2 | Transmit start threshold |
| no_underflow | output | 1 | No-underflow mode enable |
| desc32 | output | 1 | 32-bit descriptor style selected |

## Verification
The bench goes after the corner cases where the indirect scheme breaks easily. It checks that the same index reaches different storage in the two banks; a shared decode would return the other bank's word. It writes unimplemented and identification indices and reads them back; a design that let those writes land would return the written value instead of zero or the ID. It times init-done to the exact edge, catching an off-by-one timer. It also checks that the stop bit overrides start and init in the same write, and that a soft reset in mid-init cancels the pending done. A design that got either wrong would show running or init-done set afterwards.

// File: rtl/netc_regport_pkg.sv
// Shared constants for the indirect register port: window offsets,
// command/status bit positions and fixed register indices.
package netc_regport_pkg;
    localparam logic [4:0] OFF_CSR = 5'h10;
    localparam logic [4:0] OFF_IDX = 5'h12;
    localparam logic [4:0] OFF_RST = 5'h14;
    localparam logic [4:0] OFF_BCR = 5'h16;

    localparam int B_INIT = 0;
    localparam int B_STRT = 1;
    localparam int B_STOP = 2;
    localparam int B_TDMD = 3;
    localparam int B_IDON = 8;

    localparam logic [6:0] IX_CMD   = 7'd0;
    localparam logic [6:0] IX_ID_LO = 7'd88;
    localparam logic [6:0] IX_ID_HI = 7'd89;
endpackage

// File: rtl/netc_index_ptr.sv
// Index pointer register.
// Holds the register index that both data ports use.
// Assumes that ld is a single-cycle qualified write strobe.
module netc_index_ptr #(
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [IW-1:0] din,
    output logic [IW-1:0] idx
);
    // Load the pointer on a write to its offset.
    always_ff @(posedge clk) begin
        if (!rst_n)  idx <= '0;
        else if (ld) idx <= din;
    end

    // R1
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> idx == $past(din));
endmodule

// File: rtl/netc_reg_bank.sv
// Sparse bank of stored registers.
// Only the indices listed in MAP have storage. Every other index reads
// zero and drops writes. Assumes that no index appears twice in MAP.
module netc_reg_bank #(
    parameter int              IW  = 7,
    parameter int              DW  = 16,
    parameter int              NUM = 4,
    parameter logic [NUM*IW-1:0] MAP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IW-1:0]     idx,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [NUM*DW-1:0] regs
);
    for (genvar g = 0; g < NUM; g++) begin : g_slot
        localparam logic [IW-1:0] MY_IX = MAP[g*IW +: IW];
        logic [DW-1:0] r;
        // Store the word when this slot's index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                    r <= '0;
            else if (we && idx == MY_IX)   r <= wdata;
        end
        assign regs[g*DW +: DW] = r;
    end

    // Read mux: OR of the matching slot, zero when nothing matches.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM; i++)
            if (idx == MAP[i*IW +: IW]) rdata = rdata | regs[i*DW +: DW];
    end

    // R3
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs));
endmodule

// File: rtl/netc_cmd_status.sv
// Command/status word (control register 0).
// Turns command bits into one-cycle pulses, keeps the stop/running status
// and runs the init-done timer. Assumes INIT_CYCLES >= 1 and that soft_rst
// and cmd_we are never high together (they come from different offsets).
module netc_cmd_status #(
    parameter int INIT_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic        c_init,
    input  logic        c_start,
    input  logic        c_stop,
    input  logic        c_tdmd,
    input  logic        c_idon_clr,
    input  logic        soft_rst,
    output logic        init_pulse,
    output logic        start_pulse,
    output logic        tx_poll_pulse,
    output logic        stopped,
    output logic        running,
    output logic        init_done,
    output logic [15:0] status_word
);
    import netc_regport_pkg::*;

    localparam int CW = $clog2(INIT_CYCLES + 1);

    logic          busy;
    logic [CW-1:0] cnt;

    // Command decode, status update and init-done timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stopped       <= 1'b1;
            running       <= 1'b0;
            init_done     <= 1'b0;
            busy          <= 1'b0;
            cnt           <= '0;
            init_pulse    <= 1'b0;
            start_pulse   <= 1'b0;
            tx_poll_pulse <= 1'b0;
        end else begin
            init_pulse    <= 1'b0;
            start_pulse   <= 1'b0;
            tx_poll_pulse <= 1'b0;
            if (soft_rst) begin
                stopped   <= 1'b1;
                running   <= 1'b0;
                init_done <= 1'b0;
                busy      <= 1'b0;
            end else begin
                if (busy) begin
                    if (cnt == CW'(1)) begin
                        init_done <= 1'b1;
                        busy      <= 1'b0;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                if (cmd_we) begin
                    if (c_idon_clr) init_done     <= 1'b0;
                    if (c_tdmd)     tx_poll_pulse <= 1'b1;
                    if (c_stop) begin
                        stopped <= 1'b1;
                        running <= 1'b0;
                        busy    <= 1'b0;
                    end else begin
                        if (c_init) begin
                            init_pulse <= 1'b1;
                            stopped    <= 1'b0;
                            busy       <= 1'b1;
                            cnt        <= CW'(INIT_CYCLES);
                        end
                        if (c_start) begin
                            start_pulse <= 1'b1;
                            stopped     <= 1'b0;
                            running     <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // Readback: command bits read zero; status and done flag are kept.
    always_comb begin
        status_word         = '0;
        status_word[B_STOP] = stopped;
        status_word[B_STRT] = running;
        status_word[B_IDON] = init_done;
    end

    // R4
    rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> stopped && !running && !init_done);
    // R5
    start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> running && !stopped);
    // R7
    idon_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(busy));
    // R9
    srst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> stopped && !running && !init_done && !busy);
endmodule

// File: rtl/netc_regport.sv
// Indirect register port, top level.
// Decodes the four-word I/O window, routes data-port accesses to the
// control or configuration bank through the shared index pointer, and
// returns registered read data. Assumes one access per req cycle and DW=16.
module netc_regport #(
    parameter int          IW          = 7,
    parameter int          DW          = 16,
    parameter int          INIT_CYCLES = 8,
    parameter logic [15:0] PART_CODE   = 16'h2625
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          wr,
    input  logic [4:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          init_pulse,
    output logic          start_pulse,
    output logic          tx_poll_pulse,
    output logic          soft_rst_pulse,
    output logic          stopped,
    output logic          running,
    output logic          init_done,
    output logic [31:0]   init_blk_addr,
    output logic [1:0]    tx_thresh,
    output logic          no_underflow,
    output logic          desc32
);
    import netc_regport_pkg::*;

    localparam int          NSLOT   = 4;
    localparam logic [31:0] ID_WORD = {4'b0, PART_CODE, 12'h003};
    localparam logic [NSLOT*IW-1:0] CSR_MAP = {7'd80, 7'd4, 7'd2, 7'd1};
    localparam logic [NSLOT*IW-1:0] BCR_MAP = {7'd32, 7'd20, 7'd18, 7'd2};

    logic                rd_acc, wr_acc;
    logic                sel_csr, sel_idx, sel_rst, sel_bcr;
    logic [IW-1:0]       idx;
    logic [DW-1:0]       csr_rd, bcr_rd, cmd_word, rd_val;
    logic [NSLOT*DW-1:0] csr_regs, bcr_regs;
    logic                soft_rst;

    assign rd_acc   = req && !wr;
    assign wr_acc   = req && wr;
    assign sel_csr  = addr == OFF_CSR;
    assign sel_idx  = addr == OFF_IDX;
    assign sel_rst  = addr == OFF_RST;
    assign sel_bcr  = addr == OFF_BCR;
    assign soft_rst = rd_acc && sel_rst;

    netc_index_ptr #(.IW(IW)) u_idx (
        .clk(clk), .rst_n(rst_n), .ld(wr_acc && sel_idx),
        .din(wdata[IW-1:0]), .idx(idx)
    );

    netc_reg_bank #(.IW(IW), .DW(DW), .NUM(NSLOT), .MAP(CSR_MAP)) u_csr (
        .clk(clk), .rst_n(rst_n), .we(wr_acc && sel_csr), .idx(idx),
        .wdata(wdata), .rdata(csr_rd), .regs(csr_regs)
    );

    netc_reg_bank #(.IW(IW), .DW(DW), .NUM(NSLOT), .MAP(BCR_MAP)) u_bcr (
        .clk(clk), .rst_n(rst_n), .we(wr_acc && sel_bcr), .idx(idx),
        .wdata(wdata), .rdata(bcr_rd), .regs(bcr_regs)
    );

    netc_cmd_status #(.INIT_CYCLES(INIT_CYCLES)) u_cmd (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(wr_acc && sel_csr && idx == IX_CMD),
        .c_init(wdata[B_INIT]), .c_start(wdata[B_STRT]),
        .c_stop(wdata[B_STOP]), .c_tdmd(wdata[B_TDMD]),
        .c_idon_clr(wdata[B_IDON]), .soft_rst(soft_rst),
        .init_pulse(init_pulse), .start_pulse(start_pulse),
        .tx_poll_pulse(tx_poll_pulse), .stopped(stopped),
        .running(running), .init_done(init_done), .status_word(cmd_word)
    );

    // Read value select for the addressed window word.
    always_comb begin
        rd_val = '0;
        if (sel_idx) begin
            rd_val = DW'(idx);
        end else if (sel_csr) begin
            if (idx == IX_CMD)        rd_val = cmd_word;
            else if (idx == IX_ID_LO) rd_val = ID_WORD[15:0];
            else if (idx == IX_ID_HI) rd_val = ID_WORD[31:16];
            else                      rd_val = csr_rd;
        end else if (sel_bcr) begin
            rd_val = bcr_rd;
        end
    end

    // Register read data on an accepted read; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_acc) rdata <= rd_val;
    end

    // One-cycle software reset indication.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_rst_pulse <= 1'b0;
        else        soft_rst_pulse <= soft_rst;
    end

    // Configuration fields for neighbouring blocks (slot order follows MAP).
    assign init_blk_addr = {csr_regs[1*DW +: DW], csr_regs[0*DW +: DW]};
    assign tx_thresh     = csr_regs[3*DW + 10 +: 2];
    assign no_underflow  = bcr_regs[1*DW + 11];
    assign desc32        = bcr_regs[2*DW +: 8] == 8'd2;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{csr_regs[2*DW +: DW], csr_regs[3*DW +: 10],
                               csr_regs[3*DW + 12 +: DW-12],
                               bcr_regs[0 +: DW], bcr_regs[1*DW +: 11],
                               bcr_regs[1*DW + 12 +: DW-12],
                               bcr_regs[2*DW + 8 +: DW-8],
                               bcr_regs[3*DW +: DW], wdata[DW-1:IW]};

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && !wr) |=> $stable(rdata));
    // R9
    srst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |-> rdata == '0 && stopped);
endmodule

// File: tb/tb_netc_regport.sv
module tb_netc_regport;
    localparam int INIT_CYCLES = 8;
    localparam int NV = 34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        init_pulse, start_pulse, tx_poll_pulse, soft_rst_pulse;
    logic        stopped, running, init_done, no_underflow, desc32;
    logic [31:0] init_blk_addr;
    logic [1:0]  tx_thresh;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    netc_regport #(.INIT_CYCLES(INIT_CYCLES)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .init_pulse(init_pulse),
        .start_pulse(start_pulse), .tx_poll_pulse(tx_poll_pulse),
        .soft_rst_pulse(soft_rst_pulse), .stopped(stopped),
        .running(running), .init_done(init_done),
        .init_blk_addr(init_blk_addr), .tx_thresh(tx_thresh),
        .no_underflow(no_underflow), .desc32(desc32)
    );

    // Vector: {check, write, addr, wdata, expected, requirement number}
    localparam logic [42:0] VEC [NV] = '{
        {1'b0, 1'b1, 5'h12, 16'd88,    16'h0000, 4'd1},  // R1 load 88
        {1'b1, 1'b0, 5'h12, 16'd0,     16'd88,   4'd1},  // R1 read back
        {1'b0, 1'b1, 5'h12, 16'd1,     16'h0000, 4'd2},
        {1'b0, 1'b1, 5'h10, 16'h1234,  16'h0000, 4'd2},
        {1'b0, 1'b1, 5'h12, 16'd2,     16'h0000, 4'd2},
        {1'b0, 1'b1, 5'h10, 16'hABCD,  16'h0000, 4'd2},
        {1'b0, 1'b1, 5'h12, 16'd1,     16'h0000, 4'd2},
        {1'b1, 1'b0, 5'h10, 16'd0,     16'h1234, 4'd2},  // R2 ctl 1
        {1'b0, 1'b1, 5'h12, 16'd2,     16'h0000, 4'd2},
        {1'b1, 1'b0, 5'h10, 16'd0,     16'hABCD, 4'd2},  // R2 ctl 2
        {1'b0, 1'b1, 5'h12, 16'd80,    16'h0000, 4'd2},
        {1'b0, 1'b1, 5'h10, 16'h0C00,  16'h0000, 4'd2},
        {1'b1, 1'b0, 5'h10, 16'd0,     16'h0C00, 4'd2},  // R2 ctl 80
        {1'b0, 1'b1, 5'h12, 16'd18,    16'h0000, 4'd2},
        {1'b0, 1'b1, 5'h16, 16'h0800,  16'h0000, 4'd2},
        {1'b0, 1'b1, 5'h12, 16'd20,    16'h0000, 4'd2},
        {1'b0, 1'b1, 5'h16, 16'h0002,  16'h0000, 4'd2},
        {1'b0, 1'b1, 5'h12, 16'd2,     16'h0000, 4'd2},
        {1'b0, 1'b1, 5'h16, 16'h5A5A,  16'h0000, 4'd2},
        {1'b1, 1'b0, 5'h16, 16'd0,     16'h5A5A, 4'd2},  // R2 cfg 2, not ctl 2
        {1'b0, 1'b1, 5'h12, 16'd18,    16'h0000, 4'd2},
        {1'b1, 1'b0, 5'h16, 16'd0,     16'h0800, 4'd2},  // R2 cfg 18
        {1'b1, 1'b0, 5'h10, 16'd0,     16'h0000, 4'd3},  // R3 ctl 18 absent
        {1'b0, 1'b1, 5'h12, 16'd5,     16'h0000, 4'd3},
        {1'b0, 1'b1, 5'h10, 16'hFFFF,  16'h0000, 4'd3},
        {1'b1, 1'b0, 5'h10, 16'd0,     16'h0000, 4'd3},  // R3 ctl 5
        {1'b0, 1'b1, 5'h16, 16'h1111,  16'h0000, 4'd3},
        {1'b1, 1'b0, 5'h16, 16'd0,     16'h0000, 4'd3},  // R3 cfg 5
        {1'b0, 1'b1, 5'h12, 16'd88,    16'h0000, 4'd10},
        {1'b0, 1'b1, 5'h10, 16'h0000,  16'h0000, 4'd10},
        {1'b1, 1'b0, 5'h10, 16'd0,     16'h5003, 4'd10}, // R10 ID low kept
        {1'b0, 1'b1, 5'h12, 16'd89,    16'h0000, 4'd10},
        {1'b1, 1'b0, 5'h10, 16'd0,     16'h0262, 4'd10}, // R10 ID high
        {1'b1, 1'b0, 5'h1E, 16'd0,     16'h0000, 4'd12}  // R12 unused offset
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; wr = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] a);
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4 reset state
        check("R4 stopped", {31'b0, stopped}, 32'd1);
        check("R4 pulses", {28'b0, init_pulse, start_pulse, tx_poll_pulse, init_done}, 32'd0);
        check("R4 init addr", init_blk_addr, 32'd0);
        do_read(5'h10);
        check("R4 ctl0", {16'b0, rdata}, 32'h0004);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][41]) do_write(VEC[i][40:36], VEC[i][35:20]);
            else            do_read(VEC[i][40:36]);
            if (VEC[i][42])
                check($sformatf("R%0d vector %0d", VEC[i][3:0], i), {16'b0, rdata}, {16'b0, VEC[i][19:4]});
        end

        // R12 read data holds across a write
        do_read(5'h12);
        do_write(5'h12, 16'd1);
        repeat (2) @(negedge clk);
        check("R12 hold", {16'b0, rdata}, 32'd89);

        // R11 configuration fields
        check("R11 init addr", init_blk_addr, 32'hABCD1234);
        check("R11 fields", {28'b0, tx_thresh, no_underflow, desc32}, 32'hF);

        // R5 init command, R7 exact done timing
        do_write(5'h12, 16'd0);
        do_write(5'h10, 16'h0001);
        check("R5 init pulse", {30'b0, init_pulse, stopped}, 32'h2);
        @(negedge clk);
        check("R5 init pulse width", {31'b0, init_pulse}, 32'd0);
        repeat (INIT_CYCLES - 2) @(negedge clk);
        check("R7 done early", {31'b0, init_done}, 32'd0);
        @(negedge clk);
        check("R7 done on time", {31'b0, init_done}, 32'd1);
        do_read(5'h10);
        check("R7 ctl0 readback", {16'b0, rdata}, 32'h0100);

        // R8 clear of done flag
        do_write(5'h10, 16'h0000);
        check("R8 kept", {31'b0, init_done}, 32'd1);
        do_write(5'h10, 16'h0100);
        check("R8 cleared", {31'b0, init_done}, 32'd0);

        // R5 start
        do_write(5'h10, 16'h0002);
        check("R5 start pulse", {31'b0, start_pulse}, 32'd1);
        do_read(5'h10);
        check("R5 running readback", {16'b0, rdata}, 32'h0002);

        // R6 transmit poll
        do_write(5'h10, 16'h0008);
        check("R6 poll pulse", {31'b0, tx_poll_pulse}, 32'd1);
        @(negedge clk);
        check("R6 poll width", {31'b0, tx_poll_pulse}, 32'd0);
        do_read(5'h10);
        check("R6 status kept", {16'b0, rdata}, 32'h0002);

        // R5 stop overrides init and start
        do_write(5'h10, 16'h0007);
        check("R5 stop prio", {28'b0, init_pulse, start_pulse, running, stopped}, 32'h1);
        do_read(5'h10);
        check("R5 stop readback", {16'b0, rdata}, 32'h0004);

        // R9 soft reset during pending init
        do_write(5'h10, 16'h0003);
        repeat (2) @(negedge clk);
        do_read(5'h14);
        check("R9 reset read", {15'b0, soft_rst_pulse, rdata}, 32'h10000);
        repeat (INIT_CYCLES + 2) @(negedge clk);
        check("R9 init cancelled", {30'b0, running, init_done}, 32'd0);
        do_read(5'h10);
        check("R9 ctl0", {16'b0, rdata}, 32'h0004);
        do_write(5'h12, 16'd1);
        do_read(5'h10);
        check("R9 storage kept", {16'b0, rdata}, 32'h1234);

        finish_run();
    end
endmodule